// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits at the front of an Ethernet receive path and makes the accept-or-drop decision for each incoming frame from its destination address alone. Software first loads two things through a byte-wide write port: a 48-bit station address and a 64-bit group-address hash table. The receive logic then pulses a frame-start strobe and presents the destination address one byte per valid cycle, in the order the bytes arrive on the wire.

The first destination byte decides the address class. If bit 0 of that byte is clear, the address is an individual (unicast) address, and it passes only when all 48 bits equal the station address. If bit 0 is set, the address is a group address; broadcast is simply one such address. A CRC-32 is run over the six bytes as they arrive. The low six bits of that CRC select one bit of the hash table, and that bit decides the frame. Broadcast has no dedicated comparator, so software must set the table bit that the all-ones address hashes to. A promiscuous control input overrides every decision and accepts the frame.

One cycle after the sixth byte, the block produces a single-cycle verdict strobe together with an accept flag.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `verdictStrobe` and `verdictAccept` are low, both tables are cleared to zero, and bytes presented before the first `frameStart` produce no verdict.
- R2: A write with `regWrEn` high stores `regWrData` at index `regAddr`. Indices 0x10 to 0x15 hold the station address, with 0x10 compared against the first received destination byte and 0x15 against the sixth. Writes to indices outside 0x10 to 0x1D change no filter state.
- R3: Indices 0x16 to 0x1D hold the 64-bit hash table, least significant byte at 0x16. Hash index n selects bit (n mod 8) of the byte at index 0x16 + n/8, which is bit n of the 64-bit vector.
- R4: When bit 0 of the first destination byte is 0, the frame is accepted only if all six bytes equal the station address. A difference in any single byte rejects it.
- R5: When bit 0 of the first destination byte is 1, the frame is accepted exactly when the table bit at the hash index is 1. The hash index is the low 6 bits of a CRC-32 with these properties: reflected polynomial 0xEDB88320, each byte processed LSB first, register seeded with all ones, and no final complement.
- R6: The all-ones broadcast address is handled as a group address only. It is rejected when its hash bit is 0 and accepted when that bit is 1, even if every other table bit is 0.
- R7: While `promiscEn` is high in the cycle of the sixth byte, the verdict is accept, whatever the address and tables hold.
- R8: `verdictStrobe` is a one-cycle pulse in the cycle after the sixth accepted byte. `verdictAccept` is low whenever `verdictStrobe` is low. Bytes after the sixth are ignored until the next `frameStart`.
- R9: `frameStart` discards any partial address and re-seeds the CRC. A byte presented in the same cycle as `frameStart` counts as the first byte of the new frame.
- R10: Cycles with `byteValid` low may occur between address bytes without changing the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 8 | Register index for the write |
| regWrData | input | 8 | Register write data |
| promiscEn | input | 1 | Accept every frame when high |
| frameStart | input | 1 | Start of a new destination address |
| byteValid | input | 1 | `byteData` carries an address byte |
| byteData | input | 8 | Destination address byte, wire order |
| verdictStrobe | output | 1 | One-cycle verdict pulse |
| verdictAccept | output | 1 | Frame accepted, valid with `verdictStrobe` |

## Verification
The hardest case to reach from the ports is a group address whose verdict hangs on one specific table bit. The index is a CRC over all six bytes, so a test cannot aim at a chosen bit by picking addresses. The bench therefore computes each address's hash index with its own bit-serial CRC and writes exactly that bit. It then clears the bit again, including the broadcast case with all other bits zero. Restarts partway through an address and a frame-start coinciding with a byte are driven on purpose. A cycle-level reference model checks that only the new frame's bytes produce the single verdict.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int BYTE_W     = 8;
  localparam int MAC_BYTES  = 6;
  localparam int HASH_BITS  = 64;
  localparam int HASH_BYTES = HASH_BITS / BYTE_W;
  localparam int HIDX_W     = $clog2(HASH_BITS);
  localparam int CNT_W      = $clog2(MAC_BYTES + 1);
  localparam int ADDR_W     = 8;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;
  localparam logic [ADDR_W-1:0] STA_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] HASH_BASE = 8'h16;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             clrCrc;
    logic             loadByte;
    logic             lastByte;
    logic [CNT_W-1:0] byteIdx;
  } ctrlStrobes_t;

  // One byte of reflected CRC-32, LSB first, no inversion
  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  input  logic         byteValid,
  output ctrlStrobes_t strobes
);
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] effCnt;
  logic             takeByte;

  // R9: a frame start restarts the count in the same cycle
  assign effCnt   = frameStart ? '0 : byteCnt;
  // R8: only the first MAC_BYTES bytes are taken
  assign takeByte = byteValid && (effCnt < CNT_W'(MAC_BYTES));

  always_comb begin
    strobes.clrCrc   = frameStart;
    strobes.loadByte = takeByte;
    strobes.lastByte = takeByte && (effCnt == CNT_W'(MAC_BYTES - 1));
    strobes.byteIdx  = effCnt;
  end

  // R1: idle (full) count after reset, so stray bytes are ignored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         byteCnt <= CNT_W'(MAC_BYTES);
    else if (takeByte) byteCnt <= effCnt + 1'b1;
    else               byteCnt <= effCnt;
  end
endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              promiscEn,
  input  logic [BYTE_W-1:0] byteData,
  input  ctrlStrobes_t      strobes,
  output logic              verdictStrobe,
  output logic              verdictAccept
);
  logic [BYTE_W-1:0]    staReg  [MAC_BYTES];
  logic [BYTE_W-1:0]    hashReg [HASH_BYTES];
  logic [BYTE_W-1:0]    destBuf [MAC_BYTES-1];
  logic [HASH_BITS-1:0] hashVec;
  logic [MAC_BYTES-1:0] byteMatch;
  logic [CRC_W-1:0]     crcReg, crcIn, crcNext;
  logic [HIDX_W-1:0]    hashIdx;
  logic                 isGroup, hashHit, uniHit, decision;

  // R2: station address registers, index STA_BASE + k holds wire byte k
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_sta
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) staReg[g] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(STA_BASE + g)) staReg[g] <= regWrData;
    end
  end

  // R3: hash table bytes, least significant at HASH_BASE
  for (genvar g = 0; g < HASH_BYTES; g++) begin : g_hash
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hashReg[g] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(HASH_BASE + g)) hashReg[g] <= regWrData;
    end
    assign hashVec[g*BYTE_W +: BYTE_W] = hashReg[g];
  end

  // Capture all but the final byte; the final one is compared in flight
  for (genvar g = 0; g < MAC_BYTES - 1; g++) begin : g_dest
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) destBuf[g] <= '0;
      else if (strobes.loadByte && strobes.byteIdx == CNT_W'(g)) destBuf[g] <= byteData;
    end
  end

  // R4: per-byte exact comparison
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_cmp
    if (g == MAC_BYTES - 1) begin : g_live
      assign byteMatch[g] = (byteData == staReg[g]);
    end else begin : g_held
      assign byteMatch[g] = (destBuf[g] == staReg[g]);
    end
  end

  // R5 / R9: CRC seeded on frame start, advanced per taken byte
  assign crcIn   = strobes.clrCrc ? CRC_SEED : crcReg;
  assign crcNext = crcByte(crcIn, byteData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 crcReg <= CRC_SEED;
    else if (strobes.loadByte) crcReg <= crcNext;
    else if (strobes.clrCrc)   crcReg <= CRC_SEED;
  end

  assign hashIdx = crcNext[HIDX_W-1:0];
  assign hashHit = hashVec[hashIdx];
  assign uniHit  = &byteMatch;
  assign isGroup = destBuf[0][0];   // R4/R5/R6: class from first wire byte bit 0

  // R7: promiscuous overrides the class decision
  always_comb begin
    if (promiscEn)    decision = 1'b1;
    else if (isGroup) decision = hashHit;
    else              decision = uniHit;
  end

  // R8: registered single-cycle verdict
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verdictStrobe <= 1'b0;
      verdictAccept <= 1'b0;
    end else begin
      verdictStrobe <= strobes.lastByte;
      verdictAccept <= strobes.lastByte && decision;
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              promiscEn,
  input  logic              frameStart,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              verdictStrobe,
  output logic              verdictAccept
);
  ctrlStrobes_t strobes;

  mhf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .byteValid  (byteValid),
    .strobes    (strobes)
  );

  mhf_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .promiscEn     (promiscEn),
    .byteData      (byteData),
    .strobes       (strobes),
    .verdictStrobe (verdictStrobe),
    .verdictAccept (verdictAccept)
  );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker
  import mhf_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic byteValid,
  input logic promiscEn,
  input logic verdictStrobe,
  input logic verdictAccept
);
  logic [CNT_W-1:0] seen;
  logic [CNT_W-1:0] seenEff;
  logic             sixthLast;

  // Independent byte tracker
  assign seenEff = frameStart ? '0 : seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen      <= CNT_W'(MAC_BYTES);
      sixthLast <= 1'b0;
    end else begin
      sixthLast <= byteValid && (seenEff == CNT_W'(MAC_BYTES - 1));
      if (byteValid && seenEff < CNT_W'(MAC_BYTES)) seen <= seenEff + 1'b1;
      else                                          seen <= seenEff;
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    verdictStrobe |=> !verdictStrobe);                                   // R8
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    !verdictStrobe |-> !verdictAccept);                                  // R8
  AST_STROBE_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rstN)
    verdictStrobe |-> sixthLast);                                        // R8
  AST_SIXTH_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    sixthLast |-> verdictStrobe);                                        // R9
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (verdictStrobe && $past(promiscEn)) |-> verdictAccept);              // R7
endmodule

bind mcast_hash_filter mhf_checker u_mhf_checker (
  .clk           (clk),
  .rstN          (rstN),
  .frameStart    (frameStart),
  .byteValid     (byteValid),
  .promiscEn     (promiscEn),
  .verdictStrobe (verdictStrobe),
  .verdictAccept (verdictAccept)
);

// File: tb/test_mcast_hash_filter.sv
`timescale 1ns/1ps
module test_mcast_hash_filter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       promiscEn = 1'b0;
  logic       frameStart = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       verdictStrobe, verdictAccept;

  int    checks = 0;
  int    errors = 0;
  int    verdicts = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  mcast_hash_filter i_mcast_hash_filter (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .promiscEn(promiscEn), .frameStart(frameStart),
    .byteValid(byteValid), .byteData(byteData),
    .verdictStrobe(verdictStrobe), .verdictAccept(verdictAccept)
  );

  // Reference: bit-serial reflected CRC, seed all ones, no complement
  function automatic int hashOf(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic fb = c[0] ^ a[n];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return int'(c[5:0]);
  endfunction

  // ---------- reference model ----------
  logic [7:0]  mSta [6];
  logic [63:0] mHash;
  logic [7:0]  mQ[$];
  bit          mActive;
  logic        expStrobe, expAccept;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 6; k++) mSta[k] = '0;
      mHash = '0; mQ.delete(); mActive = 0;
      expStrobe = 0; expAccept = 0;
    end else begin
      expStrobe = 0; expAccept = 0;
      if (frameStart) begin mQ.delete(); mActive = 1; end
      if (byteValid && mActive && mQ.size() < 6) begin
        mQ.push_back(byteData);
        if (mQ.size() == 6) begin
          logic [47:0] a;
          bit hit;
          for (int k = 0; k < 6; k++) a[8*k +: 8] = mQ[k];
          if (promiscEn)    hit = 1;
          else if (a[0])    hit = mHash[hashOf(a)];
          else begin
            hit = 1;
            for (int k = 0; k < 6; k++) if (mQ[k] != mSta[k]) hit = 0;
          end
          expStrobe = 1; expAccept = hit;
        end
      end
      if (regWrEn) begin
        if (regAddr >= 8'h10 && regAddr <= 8'h15) mSta[regAddr - 8'h10] = regWrData;
        else if (regAddr >= 8'h16 && regAddr <= 8'h1D)
          mHash[8*(regAddr - 8'h16) +: 8] = regWrData;
      end
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (verdictStrobe !== expStrobe || verdictAccept !== expAccept) begin
        errors++;
        $display("FAIL %s: strobe/accept=%0b/%0b expected %0b/%0b at %0t",
                 phase, verdictStrobe, verdictAccept, expStrobe, expAccept, $time);
      end
      if (verdictStrobe) verdicts++;
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic setHashBit(input int idx, input bit val);
    logic [7:0] cur;
    cur = mHash[8*(idx/8) +: 8];
    cur[idx%8] = val;
    wrReg(8'h16 + 8'(idx/8), cur);
  endtask

  task automatic sendAddr(input logic [47:0] a, input int gap, input int extra);
    frameStart = 1; @(negedge clk); frameStart = 0;
    for (int k = 0; k < 6 + extra; k++) begin
      byteValid = 1; byteData = a[8*(k%6) +: 8];
      @(negedge clk);
      byteValid = 0;
      repeat (gap) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expectVerdicts(input int n, input string tag);
    checks++;
    if (verdicts != n) begin
      errors++;
      $display("FAIL %s: verdict count %0d expected %0d", tag, verdicts, n);
    end
  endtask

  localparam logic [47:0] STA = 48'h55_44_33_22_11_02; // wire bytes 02 11 22 33 44 55

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    phase = "R1";
    checks++;
    if (verdictStrobe !== 0 || verdictAccept !== 0) begin
      errors++;
      $display("FAIL R1: reset outputs %0b/%0b expected 0/0", verdictStrobe, verdictAccept);
    end
    for (int k = 0; k < 6; k++) begin   // bytes before any frame start
      byteValid = 1; byteData = 8'(k); @(negedge clk);
    end
    byteValid = 0; repeat (2) @(negedge clk);
    expectVerdicts(0, "R1");

    phase = "R2";
    for (int k = 0; k < 6; k++) wrReg(8'h10 + 8'(k), STA[8*k +: 8]);
    wrReg(8'h0F, 8'hFF); wrReg(8'h1E, 8'hFF); wrReg(8'hFE, 8'h00);
    sendAddr(STA, 0, 0);
    expectVerdicts(1, "R2");

    phase = "R4";
    sendAddr(STA ^ 48'h01_00_00_00_00_00, 0, 0);   // last byte differs
    sendAddr(STA ^ 48'h00_00_00_00_00_04, 0, 0);   // first byte differs, still unicast
    sendAddr(STA ^ 48'h00_00_80_00_00_00, 0, 0);
    sendAddr(STA, 0, 0);

    phase = "R5";
    begin
      logic [47:0] g1 = 48'h01_00_00_5E_00_01;
      logic [47:0] g2 = 48'h FB_00_00_5E_00_01;
      sendAddr(g1, 0, 0);                 // table clear: reject
      setHashBit(hashOf(g1), 1);
      sendAddr(g1, 0, 0);                 // accept
      sendAddr(g2, 0, 0);                 // per model
      setHashBit(hashOf(g1), 0);
      sendAddr(g1, 0, 0);
    end

    phase = "R3";
    for (int k = 0; k < 8; k++) wrReg(8'h16 + 8'(k), 8'hA5 ^ 8'(k * 37));
    for (int k = 0; k < 10; k++) begin
      logic [47:0] a = {8'(k * 29), 8'(k * 7), 8'h5E, 8'(k), 8'h00, 8'(8'h01 | 8'(k << 1))};
      sendAddr(a, 0, 0);
    end

    phase = "R6";
    for (int k = 0; k < 8; k++) wrReg(8'h16 + 8'(k), 8'h00);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, 0);   // bit clear: reject
    setHashBit(hashOf(48'hFFFF_FFFF_FFFF), 1);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, 0);   // accept

    phase = "R7";
    promiscEn = 1;
    sendAddr(48'h12_34_56_78_9A_BC, 0, 0);
    sendAddr(48'h0000_0000_0001, 0, 0);
    promiscEn = 0;
    sendAddr(48'h12_34_56_78_9A_BC, 0, 0);

    phase = "R8";
    verdicts = 0;
    sendAddr(STA, 0, 5);                   // extra bytes ignored
    expectVerdicts(1, "R8");

    phase = "R9";
    verdicts = 0;
    frameStart = 1; @(negedge clk); frameStart = 0;
    for (int k = 0; k < 3; k++) begin byteValid = 1; byteData = 8'hEE; @(negedge clk); end
    frameStart = 1; byteValid = 1; byteData = STA[7:0]; @(negedge clk); // same-cycle first byte
    frameStart = 0;
    for (int k = 1; k < 6; k++) begin byteData = STA[8*k +: 8]; @(negedge clk); end
    byteValid = 0; repeat (2) @(negedge clk);
    expectVerdicts(1, "R9");

    phase = "R10";
    sendAddr(STA, 2, 0);
    sendAddr(STA ^ 48'h00_10_00_00_00_00, 3, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule